// File: doc/BRIEF.md
# Low-Side Driver Fault Supervisor

This block watches a bank of low-side output channels and decides when each of them must be switched off. Every channel has its own raw overcurrent flag. A flag that stays high long enough is treated as a real overcurrent. That channel is then held off for a fixed retry interval and released without any outside help. An overtemperature flag turns off every output for as long as it is high. An undervoltage flag does the same, and it also returns all channel supervision to its initial state and asks the rest of the logic to reset.

The outputs go to the gate drivers and to the step indexer. There is a per-channel off vector, a global kill, an active-low fault indication, a step-block signal that makes the indexer ignore step requests, and a logic-reset request. Both time intervals are parameters counted in clock cycles. `DEGLITCH_CYC` must be at least 2 and `RETRY_CYC` at least 1.

Each channel runs a three-state machine:
- IDLE moves to QUAL when its flag is high.
- QUAL returns to IDLE when the flag drops. It moves to TRIP when the flag has been high on `DEGLITCH_CYC` consecutive edges.
- TRIP returns to IDLE after `RETRY_CYC` edges.
- Undervoltage forces IDLE from any state.

Top module: `lsd_fault_supervisor`

## Requirements
- R1: While `rst` is high, and right after it is released, `ch_off` is all zero, `fault_n` is 1, and `step_block`, `kill_all` and `logic_rst_req` are 0.
- R2: `ch_off[i]` is set right after the clock edge that samples `oc_raw[i]` high for the `DEGLITCH_CYC`-th consecutive time. A high run that is shorter has no effect, and the count restarts from zero after any low sample.
- R3: A tripped channel keeps `ch_off[i]` high for exactly `RETRY_CYC` cycles and then clears, whatever `oc_raw[i]` does. If the flag is still high, qualification starts again from zero on the following edge.
- R4: Each channel qualifies, trips and retries independently of the others.
- R5: `fault_n` is a register. It is low in the cycle after any edge that saw some `ch_off` bit high or `ot_flag` high, and high otherwise.
- R6: `kill_all` is a register that is high in the cycle after any edge that sampled `ot_flag` or `uv_flag` high. Overtemperature does not change channel trip state.
- R7: An edge that samples `uv_flag` high returns every channel to IDLE, with `ch_off` zero and its counts cleared. `logic_rst_req` is a register that follows `uv_flag` one cycle late.
- R8: `step_block` is a register that is high in the cycle after any edge that saw a `ch_off` bit, `ot_flag` or `uv_flag` high.
- R9: Raising `rst` clears a tripped channel at once, without waiting for a clock edge or for the retry interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| oc_raw | input | NCH | Raw per-channel overcurrent flags |
| ot_flag | input | 1 | Overtemperature flag, level |
| uv_flag | input | 1 | Undervoltage flag, level |
| ch_off | output | NCH | Per-channel disable, high while the channel is in TRIP |
| kill_all | output | 1 | Global output kill |
| fault_n | output | 1 | Active-low fault indication |
| step_block | output | 1 | Tells the indexer to ignore step requests |
| logic_rst_req | output | 1 | Request to reset the downstream logic |

## Verification
The results are due at different times:
- `ch_off` changes right after the edge that samples the deciding input, because it is decoded from the channel state register.
- `fault_n`, `step_block`, `kill_all` and `logic_rst_req` each add one more register. They reflect inputs and trip state one edge later.
- `rst` acts without waiting for an edge.

The bench advances a behavioural model at each rising edge, using the input values that were present before that edge. It compares every output 2 ns after the edge, once all registers have settled. After raising reset, it makes one extra comparison before any edge, to check the asynchronous clear.

// File: rtl/lsd_fault_pkg.sv
`timescale 1ns/1ps
package lsd_fault_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_QUAL = 2'd1,
        CH_TRIP = 2'd2
    } ch_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ocp_channel_fsm.sv
`timescale 1ns/1ps
module ocp_channel_fsm
    import lsd_fault_pkg::*;
#(
    parameter int DEGLITCH_CYC = 350,
    parameter int RETRY_CYC    = 120000
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_clr,
    input  logic oc_raw,
    output logic tripped
);

    localparam int MAXC = max_of(DEGLITCH_CYC, RETRY_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(DEGLITCH_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(RETRY_CYC - 1);

    ch_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (uv_clr) begin
            st_d  = CH_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    if (oc_raw) begin
                        st_d  = CH_QUAL;
                        cnt_d = CW'(1);
                    end
                end
                CH_QUAL: begin
                    if (!oc_raw) begin
                        st_d  = CH_IDLE;
                        cnt_d = '0;
                    end else if (cnt_q == QUAL_LAST) begin
                        st_d  = CH_TRIP;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                CH_TRIP: begin
                    if (cnt_q == HOLD_LAST) begin
                        st_d  = CH_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output decode
    always_comb begin
        tripped = (st_q == CH_TRIP);
    end

endmodule

// File: rtl/fault_combiner.sv
`timescale 1ns/1ps
module fault_combiner #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trip_vec,
    input  logic           ot_flag,
    input  logic           uv_flag,
    output logic           kill_all,
    output logic           fault_n,
    output logic           step_block,
    output logic           logic_rst_req
);

    logic any_trip;

    always_comb begin
        any_trip = |trip_vec;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            kill_all      <= 1'b0;
            fault_n       <= 1'b1;
            step_block    <= 1'b0;
            logic_rst_req <= 1'b0;
        end else begin
            kill_all      <= ot_flag | uv_flag;
            fault_n       <= ~(any_trip | ot_flag);
            step_block    <= any_trip | ot_flag | uv_flag;
            logic_rst_req <= uv_flag;
        end
    end

endmodule

// File: rtl/lsd_fault_supervisor.sv
`timescale 1ns/1ps
module lsd_fault_supervisor #(
    parameter int NCH          = 4,
    parameter int DEGLITCH_CYC = 350,
    parameter int RETRY_CYC    = 120000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] oc_raw,
    input  logic           ot_flag,
    input  logic           uv_flag,
    output logic [NCH-1:0] ch_off,
    output logic           kill_all,
    output logic           fault_n,
    output logic           step_block,
    output logic           logic_rst_req
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ocp_channel_fsm #(
            .DEGLITCH_CYC(DEGLITCH_CYC),
            .RETRY_CYC   (RETRY_CYC)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .uv_clr (uv_flag),
            .oc_raw (oc_raw[g]),
            .tripped(ch_off[g])
        );
    end

    fault_combiner #(
        .NCH(NCH)
    ) u_comb (
        .clk          (clk),
        .rst          (rst),
        .trip_vec     (ch_off),
        .ot_flag      (ot_flag),
        .uv_flag      (uv_flag),
        .kill_all     (kill_all),
        .fault_n      (fault_n),
        .step_block   (step_block),
        .logic_rst_req(logic_rst_req)
    );

endmodule

// File: rtl/lsd_fault_sup_chk.sv
`timescale 1ns/1ps
module lsd_fault_sup_chk #(
    parameter int NCH          = 4,
    parameter int DEGLITCH_CYC = 350,
    parameter int RETRY_CYC    = 120000
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] oc_raw,
    input logic           ot_flag,
    input logic           uv_flag,
    input logic [NCH-1:0] ch_off,
    input logic           kill_all,
    input logic           fault_n,
    input logic           step_block,
    input logic           logic_rst_req
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        int hi_cnt;
        int off_cnt;

        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                hi_cnt  <= 0;
                off_cnt <= 0;
            end else begin
                if (!oc_raw[g])
                    hi_cnt <= 0;
                else if (hi_cnt < DEGLITCH_CYC)
                    hi_cnt <= hi_cnt + 1;
                if (!ch_off[g])
                    off_cnt <= 0;
                else
                    off_cnt <= off_cnt + 1;
            end
        end

        // R2: a trip needs a full qualifying run of high samples
        p_qualified_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_off[g]) |-> (hi_cnt >= DEGLITCH_CYC));

        // R3: a trip never outlasts the retry interval
        p_retry_len_r3: assert property (@(posedge clk) disable iff (rst)
            ch_off[g] |-> (off_cnt < RETRY_CYC));
    end

    p_uv_clear_r7: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> (ch_off == '0));

    p_uv_req_r7: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> logic_rst_req);

    p_kill_r6: assert property (@(posedge clk) disable iff (rst)
        (ot_flag || uv_flag) |=> kill_all);

    p_hot_fault_r5: assert property (@(posedge clk) disable iff (rst)
        ot_flag |=> !fault_n);

    p_step_block_r8: assert property (@(posedge clk) disable iff (rst)
        (|ch_off) |=> step_block);

endmodule

bind lsd_fault_supervisor lsd_fault_sup_chk #(
    .NCH         (NCH),
    .DEGLITCH_CYC(DEGLITCH_CYC),
    .RETRY_CYC   (RETRY_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .oc_raw       (oc_raw),
    .ot_flag      (ot_flag),
    .uv_flag      (uv_flag),
    .ch_off       (ch_off),
    .kill_all     (kill_all),
    .fault_n      (fault_n),
    .step_block   (step_block),
    .logic_rst_req(logic_rst_req)
);

// File: tb/sim_lsd_fault_supervisor.sv
`timescale 1ns/1ps
module sim_lsd_fault_supervisor;

    localparam int NCH = 4;
    localparam int DEG = 5;
    localparam int RET = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic [NCH-1:0] oc;
    logic           ot, uv;
    logic [NCH-1:0] ch_off;
    logic           kill_all, fault_n, step_block, logic_rst_req;

    lsd_fault_supervisor #(
        .NCH(NCH), .DEGLITCH_CYC(DEG), .RETRY_CYC(RET)
    ) u0 (
        .clk(clk), .rst(rst), .oc_raw(oc), .ot_flag(ot), .uv_flag(uv),
        .ch_off(ch_off), .kill_all(kill_all), .fault_n(fault_n),
        .step_block(step_block), .logic_rst_req(logic_rst_req)
    );

    int    total = 0;
    int    bad   = 0;
    bit    finished = 0;
    string req = "R1";

    // behavioural model state
    int hi_run [NCH];
    int left   [NCH];
    bit e_fn, e_sb, e_ka, e_lr;

    function automatic void model_reset();
        for (int i = 0; i < NCH; i++) begin
            hi_run[i] = 0;
            left[i]   = 0;
        end
        e_fn = 1'b1; e_sb = 1'b0; e_ka = 1'b0; e_lr = 1'b0;
    endfunction

    function automatic logic [NCH-1:0] exp_off();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = (left[i] > 0);
        return v;
    endfunction

    function automatic void model_edge();
        bit any = 0;
        for (int i = 0; i < NCH; i++) if (left[i] > 0) any = 1;
        e_fn = !(any || ot);
        e_sb = any || ot || uv;
        e_ka = ot || uv;
        e_lr = uv;
        for (int i = 0; i < NCH; i++) begin
            if (uv) begin
                hi_run[i] = 0;
                left[i]   = 0;
            end else if (left[i] > 0) begin
                left[i] = left[i] - 1;
            end else if (oc[i]) begin
                hi_run[i] = hi_run[i] + 1;
                if (hi_run[i] == DEG) begin
                    left[i]   = RET;
                    hi_run[i] = 0;
                end
            end else begin
                hi_run[i] = 0;
            end
        end
    endfunction

    task automatic chk(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", r, what, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(req, "ch_off", int'(ch_off), int'(exp_off()));
        chk(req, "fault_n", int'(fault_n), int'(e_fn));
        chk(req, "step_block", int'(step_block), int'(e_sb));
        chk(req, "kill_all", int'(kill_all), int'(e_ka));
        chk(req, "logic_rst_req", int'(logic_rst_req), int'(e_lr));
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            if (!rst) model_edge();
            #2;
            compare_all();
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; oc = '0; ot = 1'b0; uv = 1'b0;
        model_reset();
        // R1: reset state
        req = "R1";
        step(3);
        rst = 1'b0;
        step(2);

        // R2: short run does nothing, full run trips
        req = "R2";
        oc[0] = 1'b1; step(DEG - 1);
        oc[0] = 1'b0; step(2);
        oc[0] = 1'b1; step(DEG);
        oc[0] = 1'b0; step(2);

        // R3: flag held through trip; exact retry length and requalify
        req = "R3";
        oc[0] = 1'b1; step(RET + DEG + 5);
        oc[0] = 1'b0; step(RET + 2);

        // R4: staggered independent channels
        req = "R4";
        oc[1] = 1'b1; step(2);
        oc[2] = 1'b1; step(DEG + 3);
        oc[1] = 1'b0; step(RET);
        oc[2] = 1'b0; step(RET + 2);

        // R5: fault_n follows a trip one cycle late
        req = "R5";
        oc[3] = 1'b1; step(DEG);
        oc[3] = 1'b0; step(RET + 3);

        // R6: overtemperature during a trip leaves the trip timing intact
        req = "R6";
        oc[0] = 1'b1; step(DEG);
        oc[0] = 1'b0;
        ot = 1'b1; step(4);
        ot = 1'b0; step(RET);

        // R8: overtemperature alone blocks steps
        req = "R8";
        ot = 1'b1; step(3);
        ot = 1'b0; step(3);

        // R7: undervoltage clears a trip and a pending qualification
        req = "R7";
        oc[1] = 1'b1; step(DEG + 2);
        uv = 1'b1; step(3);
        oc[1] = 1'b0; uv = 1'b0; step(4);
        oc[2] = 1'b1; step(DEG - 2);
        uv = 1'b1; step(1);
        uv = 1'b0; step(DEG);
        oc[2] = 1'b0; step(RET + 2);

        // R9: reset clears a trip at once
        req = "R9";
        oc[3] = 1'b1; step(DEG);
        oc[3] = 1'b0; step(3);
        rst = 1'b1;
        model_reset();
        #1;
        chk("R9", "ch_off async", int'(ch_off), 0);
        step(2);
        rst = 1'b0;
        step(4);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule